// File: doc/BRIEF.md
# Flag-Generating ALU with Branch Resolver

This block performs 16-bit add, subtract and compare on two operands and keeps a four-bit condition-code register holding negative, zero, overflow and carry. The same block also resolves conditional branches. It tests the branch-code byte of an instruction word against the stored condition codes, and it computes the destination address from a signed word offset relative to the incremented program counter.

Each operation is presented for one cycle with `inValid` high. All outputs are registered and appear one clock later with `outValid`. A compare followed directly by a branch therefore resolves against the compare's flags with no stall. Subtract and compare both report carry as a borrow. The signed and unsigned orderings each use their own flag combination.

Top module: `alubr_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `outValid`, `taken` and `resWrite` are 0 and `flags` is 0.
- R2: With `opSel`=2'b00 (add), `result` = `dstVal`+`srcVal` modulo 2^16 and `resWrite`=1. `flags`[3:0] = {N,Z,V,C}, where N is the result MSB, Z marks a zero result, V marks two's-complement overflow and C is the carry out.
- R3: With `opSel`=2'b01 (subtract), `result` = `dstVal`-`srcVal` modulo 2^16 and `resWrite`=1. C is set when a borrow occurs (`dstVal` < `srcVal` unsigned), and V is set on signed overflow.
- R4: With `opSel`=2'b10 (compare), `flags` are those of `srcVal`-`dstVal` computed as in R3, and `resWrite`=0.
- R5: Outputs appear exactly one cycle after `inValid`, with `outValid` high for that one cycle. Cycles with `inValid` low leave `flags` unchanged and produce no `outValid`.
- R6: With `opSel`=2'b11 (branch), `flags` keep their value and `resWrite`=0.
- R7: For a branch, `target` = `pcVal` + 2 + 2 × (`brWord`[7:0] as a signed byte), modulo 2^16. An offset of 0xFF gives `pcVal` (a branch to itself), and an offset of 0xFE gives `pcVal` - 2.
- R8: The upper byte `brWord`[15:8] selects the condition for equality and signed ordering: 0x01 always; 0x02 when Z=0; 0x03 when Z=1; 0x04 when N xor V = 0; 0x05 when N xor V = 1; 0x06 when Z or (N xor V) is 0; 0x07 when Z or (N xor V) is 1. After a compare with `srcVal` signed-below `dstVal`, 0x05 and 0x07 are taken and 0x04 and 0x06 are not.
- R9: Unsigned and single-flag conditions: 0x80 when N=0; 0x81 when N=1; 0x82 when C and Z are both 0; 0x83 when C or Z is 1; 0x84 when V=0; 0x85 when V=1; 0x86 when C=0; 0x87 when C=1. After a compare with `srcVal` unsigned-below `dstVal`, 0x87 and 0x83 are taken and 0x86 and 0x82 are not.
- R10: Any other upper-byte value (including 0x00 and 0x08) gives `taken`=0. `taken` is 0 after every non-branch operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 2 | 00 add, 01 subtract, 10 compare, 11 branch |
| srcVal | input | 16 | Source operand |
| dstVal | input | 16 | Destination operand |
| brWord | input | 16 | Branch instruction word: condition byte above, signed word offset below |
| pcVal | input | 16 | Address of the branch instruction |
| outValid | output | 1 | Registered outputs valid |
| result | output | 16 | Arithmetic result |
| resWrite | output | 1 | Result should be written back |
| flags | output | 4 | Condition codes {N,Z,V,C} |
| taken | output | 1 | Branch condition met |
| target | output | 16 | Computed branch destination |

## Verification
The bench builds the block with the default parameters: a 16-bit data width and an 8-bit offset field. These defaults put the exact two's-complement boundaries within reach: 32767 against 32768, 65535 wrapping to 0, and offsets of -128 and +127 wrapping the 16-bit address. Ordering is exercised with fixed edge pairs and with pseudo-random operand pairs. In each case, the expected branch outcome comes from integer comparison in the bench rather than from flag formulas.

// File: rtl/alubr_pkg.sv
package alubr_pkg;

  typedef enum logic [1:0] {
    OP_ADD    = 2'b00,
    OP_SUB    = 2'b01,
    OP_CMP    = 2'b10,
    OP_BRANCH = 2'b11
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic subMode;
    logic swapOps;
    logic writeRes;
    logic loadFlags;
    logic isBranch;
    logic takeBranch;
  } strobe_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

endpackage

// File: rtl/alubr_ctrl.sv
module alubr_ctrl
  import alubr_pkg::*;
#(
  parameter int CODEW = 8
) (
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [CODEW-1:0] brCode,
  input  logic [3:0]       flagsQ,
  output strobe_t          stb
);

  logic       nXorV;
  logic [7:0] baseCond;
  logic [2:0] condIdx;
  logic       condHit;
  logic       codeKnown;
  logic       brTaken;

  assign nXorV = flagsQ[FLAG_N] ^ flagsQ[FLAG_V];

  // index = {group bit, pair select}; low bit of code picks sense
  assign baseCond[0] = 1'b1;
  assign baseCond[1] = flagsQ[FLAG_Z];
  assign baseCond[2] = nXorV;
  assign baseCond[3] = flagsQ[FLAG_Z] | nXorV;
  assign baseCond[4] = flagsQ[FLAG_N];
  assign baseCond[5] = flagsQ[FLAG_C] | flagsQ[FLAG_Z];
  assign baseCond[6] = flagsQ[FLAG_V];
  assign baseCond[7] = flagsQ[FLAG_C];

  assign condIdx   = {brCode[CODEW-1], brCode[2:1]};
  assign condHit   = brCode[0] ? baseCond[condIdx] : ~baseCond[condIdx];
  assign codeKnown = (brCode[CODEW-2:3] == '0) && (brCode != '0);
  assign brTaken   = codeKnown && condHit;

  always_comb begin
    stb         = '0;
    stb.capture = inValid;
    case (aluOp_e'(opSel))
      OP_ADD: begin
        stb.writeRes  = 1'b1;
        stb.loadFlags = 1'b1;
      end
      OP_SUB: begin
        stb.subMode   = 1'b1;
        stb.writeRes  = 1'b1;
        stb.loadFlags = 1'b1;
      end
      OP_CMP: begin
        stb.subMode   = 1'b1;
        stb.swapOps   = 1'b1;
        stb.loadFlags = 1'b1;
      end
      default: begin
        stb.isBranch   = 1'b1;
        stb.takeBranch = brTaken;
      end
    endcase
  end

endmodule

// File: rtl/alubr_dpath.sv
module alubr_dpath
  import alubr_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int OFFW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] srcVal,
  input  logic [WIDTH-1:0] dstVal,
  input  logic [WIDTH-1:0] pcVal,
  input  logic [OFFW-1:0]  brOffset,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             resWrite,
  output logic [3:0]       flagsQ,
  output logic             taken,
  output logic [WIDTH-1:0] target
);

  localparam int MSB  = WIDTH - 1;
  localparam int EXTW = WIDTH - OFFW - 1;

  logic [WIDTH-1:0] opA;
  logic [WIDTH-1:0] opB;
  logic [WIDTH-1:0] opBEff;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] sumRes;
  logic [3:0]       flagsNext;
  logic [WIDTH-1:0] offScaled;
  logic [WIDTH-1:0] targetNext;

  assign opA     = stb.swapOps ? srcVal : dstVal;
  assign opB     = stb.swapOps ? dstVal : srcVal;
  assign opBEff  = stb.subMode ? ~opB : opB;
  assign sumWide = {1'b0, opA} + {1'b0, opBEff} + {{WIDTH{1'b0}}, stb.subMode};
  assign sumRes  = sumWide[WIDTH-1:0];

  always_comb begin
    flagsNext         = '0;
    flagsNext[FLAG_N] = sumRes[MSB];
    flagsNext[FLAG_Z] = (sumRes == '0);
    flagsNext[FLAG_V] = (opA[MSB] == opBEff[MSB]) && (sumRes[MSB] != opA[MSB]);
    flagsNext[FLAG_C] = stb.subMode ? ~sumWide[WIDTH] : sumWide[WIDTH];
  end

  assign offScaled  = {{EXTW{brOffset[OFFW-1]}}, brOffset, 1'b0};
  assign targetNext = pcVal + WIDTH'(2) + offScaled;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
      resWrite <= 1'b0;
      flagsQ   <= '0;
      taken    <= 1'b0;
      target   <= '0;
    end else begin
      outValid <= stb.capture;
      if (stb.capture) begin
        resWrite <= stb.writeRes;
        taken    <= stb.takeBranch;
        if (stb.writeRes)  result <= sumRes;
        if (stb.loadFlags) flagsQ <= flagsNext;
        if (stb.isBranch)  target <= targetNext;
      end else begin
        resWrite <= 1'b0;
        taken    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/alubr_top.sv
module alubr_top
  import alubr_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int OFFW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] srcVal,
  input  logic [WIDTH-1:0] dstVal,
  input  logic [WIDTH-1:0] brWord,
  input  logic [WIDTH-1:0] pcVal,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             resWrite,
  output logic [3:0]       flags,
  output logic             taken,
  output logic [WIDTH-1:0] target
);

  localparam int CODEW = WIDTH - OFFW;

  strobe_t    stb;
  logic [3:0] flagsQ;

  alubr_ctrl #(.CODEW(CODEW)) ctrl_i (
    .inValid (inValid),
    .opSel   (opSel),
    .brCode  (brWord[WIDTH-1:OFFW]),
    .flagsQ  (flagsQ),
    .stb     (stb)
  );

  alubr_dpath #(.WIDTH(WIDTH), .OFFW(OFFW)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .srcVal   (srcVal),
    .dstVal   (dstVal),
    .pcVal    (pcVal),
    .brOffset (brWord[OFFW-1:0]),
    .outValid (outValid),
    .result   (result),
    .resWrite (resWrite),
    .flagsQ   (flagsQ),
    .taken    (taken),
    .target   (target)
  );

  assign flags = flagsQ;

endmodule

// File: rtl/alubr_checker.sv
module alubr_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [1:0]       opSel,
  input logic [7:0]       brCode,
  input logic             outValid,
  input logic [WIDTH-1:0] result,
  input logic             resWrite,
  input logic [3:0]       flags,
  input logic             taken
);

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_idle_no_valid_r5: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_idle_keeps_flags_r5: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(flags));

  p_branch_keeps_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == 2'b11) |=> ($stable(flags) && !resWrite));

  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == 2'b10) |=> !resWrite);

  p_always_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == 2'b11 && brCode == 8'h01) |=> taken);

  p_taken_needs_branch_r10: assert property (@(posedge clk) disable iff (rst)
    taken |-> $past(inValid && opSel == 2'b11));

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (outValid && resWrite) |-> (flags[2] == (result == '0)));

  p_neg_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (outValid && resWrite) |-> (flags[3] == result[WIDTH-1]));

endmodule

bind alubr_top alubr_checker #(.WIDTH(WIDTH)) checker_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opSel    (opSel),
  .brCode   (brWord[WIDTH-1:WIDTH-8]),
  .outValid (outValid),
  .result   (result),
  .resWrite (resWrite),
  .flags    (flags),
  .taken    (taken)
);

// File: tb/alubr_top_tb_top.sv
module alubr_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [15:0] srcVal = '0;
  logic [15:0] dstVal = '0;
  logic [15:0] brWord = '0;
  logic [15:0] pcVal = '0;
  logic        outValid;
  logic [15:0] result;
  logic        resWrite;
  logic [3:0]  flags;
  logic        taken;
  logic [15:0] target;

  always #10 clk = ~clk;

  alubr_top dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .srcVal(srcVal), .dstVal(dstVal), .brWord(brWord), .pcVal(pcVal),
    .outValid(outValid), .result(result), .resWrite(resWrite),
    .flags(flags), .taken(taken), .target(target)
  );

  typedef struct {
    bit          isBr;
    logic [15:0] res;
    logic        wr;
    logic [3:0]  fl;
    logic        tk;
    logic [15:0] tgt;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [3:0]  mFlags = '0;
  int unsigned seed = 32'h1234_5678;

  localparam logic [7:0] C_BR = 8'h01, C_BNE = 8'h02, C_BEQ = 8'h03, C_BGE = 8'h04,
                         C_BLT = 8'h05, C_BGT = 8'h06, C_BLE = 8'h07, C_BPL = 8'h80,
                         C_BMI = 8'h81, C_BHI = 8'h82, C_BLOS = 8'h83, C_BVC = 8'h84,
                         C_BVS = 8'h85, C_BHIS = 8'h86, C_BLO = 8'h87;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic doAlu(input logic [1:0] op, input logic [15:0] s, input logic [15:0] d,
                       input string tag);
    exp_t e;
    logic [16:0] wide;
    logic [15:0] r;
    logic c;
    int ss, ds, sres;
    ss = int'($signed(s));
    ds = int'($signed(d));
    case (op)
      2'b00: begin wide = {1'b0, d} + {1'b0, s}; r = wide[15:0]; c = wide[16]; sres = ds + ss; end
      2'b01: begin r = d - s; c = (d < s); sres = ds - ss; end
      default: begin r = s - d; c = (s < d); sres = ss - ds; end
    endcase
    mFlags = {r[15], (r == 16'h0), ((sres > 32767) || (sres < -32768)), c};
    e.isBr = 0; e.res = r; e.wr = (op != 2'b10); e.fl = mFlags;
    e.tk = 1'b0; e.tgt = '0; e.tag = tag;
    @(negedge clk);
    inValid = 1'b1; opSel = op; srcVal = s; dstVal = d;
    expQ.push_back(e);
  endtask

  task automatic doBranch(input logic [7:0] code, input logic [7:0] off,
                          input logic [15:0] pc, input logic expTk, input string tag);
    exp_t e;
    int t;
    t = (int'(pc) + 2 + 2 * int'($signed(off))) & 32'hFFFF;
    e.isBr = 1; e.res = '0; e.wr = 1'b0; e.fl = mFlags;
    e.tk = expTk; e.tgt = t[15:0]; e.tag = tag;
    @(negedge clk);
    inValid = 1'b1; opSel = 2'b11; brWord = {code, off}; pcVal = pc;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  function automatic logic [15:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  task automatic signedPair(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] lo, hi;
    if ($signed(a) < $signed(b)) begin lo = a; hi = b; end
    else begin lo = b; hi = a; end
    doAlu(2'b10, lo, hi, "R4");
    doBranch(C_BLT, 8'h04, 16'h2000, 1'b1, "R8");
    doBranch(C_BGE, 8'h04, 16'h2000, 1'b0, "R8");
    doBranch(C_BGT, 8'h04, 16'h2000, 1'b0, "R8");
    doBranch(C_BLE, 8'h04, 16'h2000, 1'b1, "R8");
    doAlu(2'b10, hi, lo, "R4");
    doBranch(C_BGT, 8'hFC, 16'h2000, 1'b1, "R8");
    doBranch(C_BLT, 8'hFC, 16'h2000, 1'b0, "R8");
  endtask

  task automatic unsignedPair(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] lo, hi;
    if (a < b) begin lo = a; hi = b; end
    else begin lo = b; hi = a; end
    doAlu(2'b10, lo, hi, "R4");
    doBranch(C_BLO, 8'h10, 16'h3000, 1'b1, "R9");
    doBranch(C_BHIS, 8'h10, 16'h3000, 1'b0, "R9");
    doBranch(C_BHI, 8'h10, 16'h3000, 1'b0, "R9");
    doBranch(C_BLOS, 8'h10, 16'h3000, 1'b1, "R9");
    doAlu(2'b10, hi, lo, "R4");
    doBranch(C_BHI, 8'hF0, 16'h3000, 1'b1, "R9");
    doBranch(C_BLO, 8'hF0, 16'h3000, 1'b0, "R9");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        chk("R5", "unexpected outValid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.tag, "flags", {28'd0, flags}, {28'd0, e.fl});
        chk(e.tag, "resWrite", {31'd0, resWrite}, {31'd0, e.wr});
        chk(e.tag, "taken", {31'd0, taken}, {31'd0, e.tk});
        if (e.wr) chk(e.tag, "result", {16'd0, result}, {16'd0, e.res});
        if (e.isBr) chk(e.tag, "target", {16'd0, target}, {16'd0, e.tgt});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "outValid in reset", {31'd0, outValid}, 32'd0);
    chk("R1", "flags in reset", {28'd0, flags}, 32'd0);
    chk("R1", "taken in reset", {31'd0, taken}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outValid after reset", {31'd0, outValid}, 32'd0);
    chk("R1", "resWrite after reset", {31'd0, resWrite}, 32'd0);

    // R2 add boundaries
    doAlu(2'b00, 16'd32767, 16'd1, "R2");
    doBranch(C_BMI, 8'h00, 16'h0100, 1'b1, "R9");
    doBranch(C_BPL, 8'h00, 16'h0100, 1'b0, "R9");
    doBranch(C_BVS, 8'h00, 16'h0100, 1'b1, "R9");
    doBranch(C_BVC, 8'h00, 16'h0100, 1'b0, "R9");
    doAlu(2'b00, 16'd1, 16'd65535, "R2");
    doBranch(C_BLO, 8'h00, 16'h0100, 1'b1, "R9");
    doBranch(C_BHIS, 8'h00, 16'h0100, 1'b0, "R9");
    doBranch(C_BEQ, 8'h00, 16'h0100, 1'b1, "R8");
    doAlu(2'b00, 16'd1, 16'd32768, "R2");
    doAlu(2'b00, 16'd200, 16'd100, "R2");

    // R3 subtract with borrow
    doAlu(2'b01, 16'd32768, 16'd1, "R3");
    doAlu(2'b01, 16'd65535, 16'd1, "R3");
    doAlu(2'b01, 16'd1, 16'd1, "R3");
    doAlu(2'b01, 16'd5, 16'd9, "R3");

    // R4 compare, equal operands
    doAlu(2'b10, 16'h1234, 16'h1234, "R4");
    doBranch(C_BEQ, 8'h02, 16'h0400, 1'b1, "R8");
    doBranch(C_BNE, 8'h02, 16'h0400, 1'b0, "R8");
    doBranch(C_BLE, 8'h02, 16'h0400, 1'b1, "R8");
    doBranch(C_BGT, 8'h02, 16'h0400, 1'b0, "R8");
    doBranch(C_BLOS, 8'h02, 16'h0400, 1'b1, "R9");
    doBranch(C_BHI, 8'h02, 16'h0400, 1'b0, "R9");

    // R5 idle gap keeps flags, no outValid
    idle(1);
    @(negedge clk);
    chk("R5", "outValid while idle", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    chk("R5", "flags held while idle", {28'd0, flags}, {28'd0, mFlags});
    doBranch(C_BEQ, 8'h01, 16'h0500, 1'b1, "R5");

    // R7 target arithmetic
    doBranch(C_BR, 8'hFF, 16'h1000, 1'b1, "R7");
    doBranch(C_BR, 8'hFE, 16'h1000, 1'b1, "R7");
    doBranch(C_BR, 8'h80, 16'h0100, 1'b1, "R7");
    doBranch(C_BR, 8'h7F, 16'hFFF0, 1'b1, "R7");
    doBranch(C_BR, 8'h00, 16'h0200, 1'b1, "R7");

    // R10 unrecognized codes
    doBranch(8'h00, 8'h05, 16'h0600, 1'b0, "R10");
    doBranch(8'h08, 8'h05, 16'h0600, 1'b0, "R10");
    doBranch(8'h88, 8'h05, 16'h0600, 1'b0, "R10");
    doBranch(8'hFF, 8'h05, 16'h0600, 1'b0, "R10");

    // R8 signed ordering: fixed edges then pseudo-random
    signedPair(16'd0, 16'd1);
    signedPair(16'hFFFF, 16'd0);
    signedPair(16'h8000, 16'h7FFF);
    signedPair(16'h8000, 16'd0);
    signedPair(16'hFFD6, 16'hFFEF);
    for (int i = 0; i < 30; i++) begin
      logic [15:0] a, b;
      a = nextRand();
      b = nextRand();
      if (a == b) b = a + 16'd1;
      signedPair(a, b);
    end

    // R9 unsigned ordering
    unsignedPair(16'd0, 16'd65535);
    unsignedPair(16'd32767, 16'd32768);
    unsignedPair(16'd65534, 16'd65535);
    unsignedPair(16'd17, 16'd42);
    for (int i = 0; i < 30; i++) begin
      logic [15:0] a, b;
      a = nextRand();
      b = nextRand();
      if (a == b) b = a + 16'd1;
      unsignedPair(a, b);
    end

    idle(3);
    chk("R5", "scoreboard drained", expQ.size(), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule